// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel character into an asynchronous serial frame on a single output line. A 7-bit frame-format word picks how many data bits are sent (five to eight) and whether a parity bit is added. The parity can be even, odd, or forced to a constant level. The word also selects a short or long stop period and can hold the line in the spacing state. Bit timing comes from a 16x oversampling tick supplied from outside: every bit lasts sixteen ticks.

A one-entry holding register sits in front of the shift stage. Software can therefore queue the next byte while the current one is still on the wire, and frames follow each other with no idle bit between them. The frame format is captured when a character moves into the shift stage. The format word may be rewritten while a frame is in flight without damaging that frame. Two status outputs report whether the holding register is free and whether the whole transmitter is drained.

Top module: `sertx_top`

## Requirements
- R1: After reset the line is high (mark), `hold_empty` is 1 and `tx_empty` is 1. The line stays high whenever no frame is in progress and break is off.
- R2: A frame starts with one low bit lasting 16 ticks. The data bits follow, least significant first, 16 ticks each. The count of data bits is set by `line_ctrl[1:0]`: 00 gives five, 01 gives six, 10 gives seven, 11 gives eight.
- R3: The high stop period after the last data or parity bit lasts 16 ticks when `line_ctrl[2]` is 0. When `line_ctrl[2]` is 1 it lasts 24 ticks for five-bit characters and 32 ticks for six, seven or eight-bit characters.
- R4: When `line_ctrl[3]` is 1, one parity bit of 16 ticks is sent between the last data bit and the stop period. When it is 0, no parity bit is sent.
- R5: With parity on and `line_ctrl[5]` at 0, setting `line_ctrl[4]` to 1 makes the ones in data plus parity even. Setting it to 0 makes that count odd. Only the data bits selected by R2 take part.
- R6: With parity on and `line_ctrl[5]` at 1, the parity bit is 0 when `line_ctrl[4]` is 1 and 1 when `line_ctrl[4]` is 0, whatever the data.
- R7: While `line_ctrl[6]` is 1, `tx_out` is low from the next clock cycle on. Bit sequencing carries on unchanged underneath, so the frame ends at the same tick as it would without the break.
- R8: A write strobe while the holding register is empty stores the byte, and `hold_empty` falls on the next cycle. An idle shift stage takes that byte on the following cycle and `hold_empty` rises again. A byte written while a frame is in progress goes out directly after that frame's stop period.
- R9: A write strobe while the holding register is full is ignored. That byte is never sent.
- R10: `tx_empty` is 1 only while both the holding register and the shift stage are empty. It is 0 during every frame.
- R11: The frame format is taken from `line_ctrl[5:0]` when a character enters the shift stage. Changing those bits during a frame does not change that frame's length or bit values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_16x | input | 1 | Single-cycle pulse at sixteen times the bit rate |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| line_ctrl | input | 7 | Frame format and break control, bits as in R2 to R7 |
| tx_out | output | 1 | Serial line, registered |
| hold_empty | output | 1 | Holding register can accept a byte |
| tx_empty | output | 1 | Holding register and shift stage both empty |

## Verification
A byte strobed at one edge shows as `hold_empty` low after that edge and enters the shift stage at the next edge. The start bit reaches `tx_out` one edge later still, and break reaches `tx_out` one edge after `line_ctrl[6]` is sampled. Every check therefore samples on the falling clock edge after the register that produces the result.

The bench samples frame bits at tick 8 + 16k after it sees the falling edge. Up to one tick is lost because the start bit begins before the bench sees it, and a mid-bit sample absorbs that. Frame length is the number of ticks from the falling edge to `tx_empty` rising. It is checked to equal the sum from R2 to R4 or that sum minus one, the minus one allowing for the same lost start tick.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_t;

  typedef struct packed {
    logic [1:0] wlen;
    logic       two_stop;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
  } frame_cfg_t;

  function automatic frame_cfg_t decode_cfg(input logic [5:0] w);
    frame_cfg_t c;
    c.wlen      = w[1:0];
    c.two_stop  = w[2];
    c.par_en    = w[3];
    c.par_even  = w[4];
    c.par_stick = w[5];
    return c;
  endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (take) begin
      hold_full <= 1'b0;
    end else if (wr_stb && !hold_full) begin
      hold_full <= 1'b1;
      hold_data <= wr_data;
    end
  end

  a_r8_write_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !hold_full) |=> (hold_full && hold_data == $past(wr_data)));

  a_r8_take_drains: assert property (@(posedge clk) disable iff (rst)
    take |=> !hold_full);

  a_r9_full_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (hold_full && !take) |=> (hold_full && $stable(hold_data)));

endmodule

// File: rtl/sertx_parity.sv
module sertx_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        wlen,
  input  logic              par_even,
  input  logic              par_stick,
  output logic              par_bit
);

  localparam int MIN_BITS = DATA_W - 3;

  logic [DATA_W-1:0] used;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    if (i < MIN_BITS) begin : g_always
      assign used[i] = data[i];
    end else begin : g_sel
      localparam int K = i - MIN_BITS;
      assign used[i] = data[i] & (int'(wlen) > K);
    end
  end

  always_comb begin
    if (par_stick) par_bit = ~par_even;
    else if (par_even) par_bit = ^used;
    else par_bit = ~(^used);
  end

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  frame_cfg_t        cfg,
  output logic              take,
  output logic              busy,
  output logic              line_bit
);

  localparam int MIN_BITS = DATA_W - 3;
  localparam int TCNT_W   = $clog2(2 * OVS);
  localparam int CNT_W    = $clog2(DATA_W);
  localparam logic [TCNT_W-1:0] BIT_LAST = TCNT_W'(OVS - 1);
  localparam logic [TCNT_W-1:0] MID_LAST = TCNT_W'(OVS + OVS / 2 - 1);
  localparam logic [TCNT_W-1:0] TWO_LAST = TCNT_W'(2 * OVS - 1);

  tx_state_t          st;
  logic [TCNT_W-1:0]  tcnt;
  logic [DATA_W-1:0]  shreg;
  logic [CNT_W-1:0]   bits_left;
  logic               par_q;
  logic               par_en_q;
  logic [TCNT_W-1:0]  stop_last;
  logic [TCNT_W-1:0]  stop_last_now;
  logic [TCNT_W-1:0]  end_cnt;
  logic               par_calc;

  sertx_parity #(.DATA_W(DATA_W)) u_par (
    .data      (hold_data),
    .wlen      (cfg.wlen),
    .par_even  (cfg.par_even),
    .par_stick (cfg.par_stick),
    .par_bit   (par_calc)
  );

  always_comb begin
    if (!cfg.two_stop) stop_last_now = BIT_LAST;
    else if (cfg.wlen == 2'b00) stop_last_now = MID_LAST;
    else stop_last_now = TWO_LAST;
  end

  assign take    = (st == ST_IDLE) && hold_full;
  assign busy    = (st != ST_IDLE);
  assign end_cnt = (st == ST_STOP) ? stop_last : BIT_LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      tcnt      <= '0;
      shreg     <= '0;
      bits_left <= '0;
      par_q     <= 1'b1;
      par_en_q  <= 1'b0;
      stop_last <= BIT_LAST;
    end else if (take) begin
      st        <= ST_START;
      tcnt      <= '0;
      shreg     <= hold_data;
      bits_left <= CNT_W'(MIN_BITS - 1) + CNT_W'(cfg.wlen);
      par_q     <= par_calc;
      par_en_q  <= cfg.par_en;
      stop_last <= stop_last_now;
    end else if (tick && st != ST_IDLE) begin
      if (tcnt != end_cnt) begin
        tcnt <= tcnt + 1'b1;
      end else begin
        tcnt <= '0;
        case (st)
          ST_START: st <= ST_DATA;
          ST_DATA: begin
            if (bits_left == '0) begin
              st <= par_en_q ? ST_PAR : ST_STOP;
            end else begin
              shreg     <= shreg >> 1;
              bits_left <= bits_left - 1'b1;
            end
          end
          ST_PAR:  st <= ST_STOP;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (st)
      ST_START: line_bit = 1'b0;
      ST_DATA:  line_bit = shreg[0];
      ST_PAR:   line_bit = par_q;
      default:  line_bit = 1'b1;
    endcase
  end

  a_r3_stop_window: assert property (@(posedge clk) disable iff (rst)
    (st == ST_STOP) |-> (tcnt <= stop_last));

  a_r2_lsb_first: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DATA && tick && tcnt == BIT_LAST && bits_left != '0)
      |=> (shreg[DATA_W-2:0] == $past(shreg[DATA_W-1:1])));

  a_r11_format_frozen: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |=> ($stable(stop_last) && $stable(par_en_q) && $stable(par_q)));

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_16x,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [6:0]        line_ctrl,
  output logic              tx_out,
  output logic              hold_empty,
  output logic              tx_empty
);

  frame_cfg_t        cfg;
  logic              brk;
  logic              take;
  logic              busy;
  logic              line_bit;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;

  assign cfg = decode_cfg(line_ctrl[5:0]);
  assign brk = line_ctrl[6];

  sertx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .take      (take),
    .hold_full (hold_full),
    .hold_data (hold_data)
  );

  sertx_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_framer (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_16x),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .cfg       (cfg),
    .take      (take),
    .busy      (busy),
    .line_bit  (line_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) tx_out <= 1'b1;
    else tx_out <= brk ? 1'b0 : line_bit;
  end

  assign hold_empty = ~hold_full;
  assign tx_empty   = ~hold_full & ~busy;

  a_r7_break_forces_low: assert property (@(posedge clk) disable iff (rst)
    brk |=> !tx_out);

  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    (!brk && !busy) |=> tx_out);

endmodule

// File: tb/sim_sertx_top.sv
module sim_sertx_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_16x = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [6:0] line_ctrl = 7'h03;
  logic       tx_out;
  logic       hold_empty;
  logic       tx_empty;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  sertx_top u0 (
    .clk        (clk),
    .rst        (rst),
    .tick_16x   (tick_16x),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data),
    .line_ctrl  (line_ctrl),
    .tx_out     (tx_out),
    .hold_empty (hold_empty),
    .tx_empty   (tx_empty)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc      <= cyc + 1;
    tick_16x <= (cyc % 4 == 3);
  end

  always @(posedge clk) begin
    if (cyc > 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<=190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: act=%0d exp=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic exp_par(input logic [7:0] ctrl, input logic [7:0] d);
    int nb;
    logic x;
    nb = 5 + int'(ctrl[1:0]);
    x = 1'b0;
    for (int i = 0; i < nb; i++) x = x ^ d[i];
    if (ctrl[5]) return ~ctrl[4];
    return ctrl[4] ? x : ~x;
  endfunction

  function automatic logic exp_bit(input logic [7:0] ctrl, input logic [7:0] d, input int k);
    int nb;
    nb = 5 + int'(ctrl[1:0]);
    if (k == 0) return 1'b0;
    if (k <= nb) return d[k-1];
    if (ctrl[3] && k == nb + 1) return exp_par(ctrl, d);
    return 1'b1;
  endfunction

  function automatic int exp_ticks(input logic [7:0] ctrl);
    int nb;
    int st;
    nb = 5 + int'(ctrl[1:0]);
    if (!ctrl[2]) st = 16;
    else if (ctrl[1:0] == 2'b00) st = 24;
    else st = 32;
    return 16 * (1 + nb + int'(ctrl[3])) + st;
  endfunction

  // Receives one frame from tx_out. Optionally rewrites line_ctrl at tick ev1/ev2.
  task automatic recv(input logic [7:0] ctrl, input logic [7:0] data, input bit want_end,
                      input int ev1, input logic [6:0] v1, input int ev2, input logic [6:0] v2,
                      input bit brk_win, input string tag);
    int nb;
    int nbits;
    int n;
    int k;
    int g;
    int hi_in_brk;
    int e;
    bit brk_on;
    bit brk_chk;
    logic xb;
    nb = 5 + int'(ctrl[1:0]);
    nbits = 1 + nb + int'(ctrl[3]) + 1;
    g = 0;
    while (tx_out !== 1'b0 && g < 5000) begin
      @(negedge clk);
      g++;
    end
    chk(g < 5000, {"R2 start seen ", tag}, g, 0);
    chk(tx_empty == 1'b0, {"R10 busy during frame ", tag}, int'(tx_empty), 0);
    n = 0; k = 0; hi_in_brk = 0; brk_on = 0; brk_chk = 0; g = 0;
    while (g < 20000) begin
      if (want_end && k >= nbits && tx_empty) break;
      if (!want_end && k >= nbits) break;
      if (brk_chk && tx_out !== 1'b0) hi_in_brk++;
      if (tick_16x) begin
        n++;
        if (n == ev1) begin line_ctrl = v1; if (brk_win) brk_on = 1; end
        if (n == ev2) begin line_ctrl = v2; brk_on = 0; end
        if (k < nbits && n == 8 + 16 * k) begin
          xb = (brk_win && n > ev1 && n < ev2) ? 1'b0 : exp_bit(ctrl, data, k);
          chk(tx_out === xb, $sformatf("R2/R4/R5/R6 bit %0d %s", k, tag), int'(tx_out), int'(xb));
          k++;
        end
      end
      brk_chk = brk_on;
      @(negedge clk);
      g++;
    end
    if (brk_win) chk(hi_in_brk == 0, {"R7 line low in break ", tag}, hi_in_brk, 0);
    if (want_end) begin
      e = exp_ticks(ctrl);
      chk(n == e || n == e - 1, {"R3 frame ticks ", tag}, n, e);
      chk(tx_out === 1'b1, {"R1 idle high ", tag}, int'(tx_out), 1);
    end
  endtask

  task automatic send(input logic [7:0] ctrl, input logic [7:0] data, input string tag);
    @(negedge clk);
    line_ctrl = ctrl[6:0];
    wr_data = data;
    wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    recv(ctrl, data, 1'b1, -1, 7'h0, -1, 7'h0, 1'b0, tag);
  endtask

  initial begin
    logic [7:0] pats [6];
    pats = '{8'h00, 8'hFF, 8'h01, 8'h80, 8'h55, 8'hAA};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(tx_out === 1'b1, "R1 reset line", int'(tx_out), 1);
    chk(hold_empty === 1'b1, "R1 reset hold_empty", int'(hold_empty), 1);
    chk(tx_empty === 1'b1, "R1 reset tx_empty", int'(tx_empty), 1);

    // R2..R6 sweep over every format combination
    for (int c = 0; c < 64; c++) begin
      send(8'(c), 8'((c * 53 + 17) & 8'hFF), $sformatf("sweep c=%0d", c));
    end

    // R5 R6 data patterns under even, odd and both stick levels
    for (int p = 0; p < 6; p++) begin
      send(8'h1B, pats[p], "R5 even 8 bit");
      send(8'h0B, pats[p], "R5 odd 8 bit");
      send(8'h38, pats[p], "R6 stick zero 5 bit");
      send(8'h2A, pats[p], "R6 stick one 7 bit");
    end

    // R7 break mid-frame, sequencing continues
    @(negedge clk);
    line_ctrl = 7'h0B;
    wr_data = 8'hC3;
    wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    recv(8'h0B, 8'hC3, 1'b1, 26, 7'h4B, 60, 7'h0B, 1'b1, "R7 break");

    // R11 format change mid-frame
    @(negedge clk);
    line_ctrl = 7'h03;
    wr_data = 8'h96;
    wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    recv(8'h03, 8'h96, 1'b1, 20, 7'h3C, -1, 7'h0, 1'b0, "R11 change");
    line_ctrl = 7'h03;

    // R8 R9 R10 holding register
    @(negedge clk);
    wr_data = 8'hA5;
    wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    chk(hold_empty === 1'b0, "R8 hold_empty falls after write", int'(hold_empty), 0);
    chk(tx_empty === 1'b0, "R10 tx_empty low with byte held", int'(tx_empty), 0);
    @(negedge clk);
    chk(hold_empty === 1'b1, "R8 holding drained to shifter", int'(hold_empty), 1);
    chk(tx_empty === 1'b0, "R10 tx_empty low while shifting", int'(tx_empty), 0);
    wr_data = 8'h3C;
    wr_stb = 1'b1;
    @(negedge clk);
    chk(hold_empty === 1'b0, "R8 second byte held", int'(hold_empty), 0);
    wr_data = 8'hFF;
    @(negedge clk);
    wr_stb = 1'b0;
    chk(hold_empty === 1'b0, "R9 still full", int'(hold_empty), 0);
    recv(8'h03, 8'hA5, 1'b0, -1, 7'h0, -1, 7'h0, 1'b0, "R8 first");
    recv(8'h03, 8'h3C, 1'b1, -1, 7'h0, -1, 7'h0, 1'b0, "R8 back to back second (R9 byte not it)");
    begin
      int lows;
      lows = 0;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        if (tx_out !== 1'b1) lows++;
      end
      chk(lows == 0, "R9 ignored byte never sent", lows, 0);
      chk(tx_empty === 1'b1, "R10 empty after drain", int'(tx_empty), 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule